// File: doc/BRIEF.md
# Secure Block Access Gate

This block sits in front of a memory and judges every transaction against a per-block security table. The memory is divided into equal blocks of `2**BLK_LOG2` bytes. Each block owns one bit in the table, which the configuration logic supplies as a flat vector. A transaction whose security matches its block's bit is forwarded to the memory one cycle later. A transaction that does not match never reaches the memory. Instead the gate answers it itself, one cycle later, with zero read data and either an OK or an error response. A control input chooses which of the two.

The first denied transaction is recorded in two fault registers, and a sticky status bit is set. That status, gated by an enable bit, drives the interrupt line. Later denials are still refused, but they leave the record alone until software clears the status. A small register port holds the status, enable, set, clear and fault-record registers. Its reads are combinational on the offset.

Top module: `sec_gate`

## Requirements
- R1: The block number of an access is `tx_addr >> BLK_LOG2`. Its table word is block/32 and its bit within that word is block mod 32. Word w bit b sits at `table_bits[32*w+b]`, so the bit used is `table_bits[block]`.
- R2: A table bit of 1 admits only non-secure transactions, and a bit of 0 admits only secure ones. An admitted transaction shows `fwd_valid`=1 with its address and write flag on the cycle after the accepting edge.
- R3: A transaction with `tx_attr_known`=0 is treated as secure, whatever `tx_sec` says.
- R4: A refused transaction produces `fwd_valid`=0 and `deny_valid`=1 on the next cycle, with `deny_rdata`=0. `deny_err` then equals the value `err_resp_en` had when the transaction was accepted.
- R5: A refused transaction that arrives while the status is clear stores its address, zero-extended, at offset 0x2c. At offset 0x30 it stores the requester ID in bits 15:0, the non-secure flag in bit 16 and the block's table bit in bit 17. It also sets the status. All of this happens at the accepting edge.
- R6: While the status is set, further refusals still happen but leave offsets 0x2c and 0x30 unchanged.
- R7: `irq` is the status AND the enable. The status reads at offset 0x20 bit 0. The enable is written and read at offset 0x28 bit 0.
- R8: Writing 1 to bit 0 at offset 0x24 clears the status, and writing 1 to bit 0 at offset 0x34 sets it. Both offsets read as zero, as does any unused offset.
- R9: If a refusal and a status clear happen in the same cycle, the refusal wins. The status stays set and the new fault is recorded, replacing any earlier one.
- R10: After reset the status is 0, the enable is 1, both fault registers are 0, and `fwd_valid`, `deny_valid` and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_valid | input | 1 | Transaction presented and accepted this cycle |
| tx_addr | input | AW | Transaction byte address |
| tx_write | input | 1 | 1 for a write, 0 for a read |
| tx_sec | input | 1 | Transaction is secure |
| tx_attr_known | input | 1 | Security attribute is specified |
| tx_master | input | 16 | Requester ID |
| table_bits | input | NBLK | Per-block security bits, 1 = non-secure block |
| err_resp_en | input | 1 | Refused transactions get an error response |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | RAW | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| fwd_valid | output | 1 | Admitted transaction goes to memory |
| fwd_addr | output | AW | Address of forwarded transaction |
| fwd_write | output | 1 | Write flag of forwarded transaction |
| deny_valid | output | 1 | Gate answers a refused transaction |
| deny_err | output | 1 | Answer is a bus error |
| deny_rdata | output | 32 | Read data of the answer, always zero |
| irq | output | 1 | Interrupt request |

## Verification
Every effect of a transaction or register write lands at the first clock edge after it is presented. This covers forwarding, refusal answers, fault capture, status, enable and the interrupt. Register reads, by contrast, reflect state in the same cycle. The bench drives inputs on the falling edge and advances its reference model with exactly the next-state rule at the rising edge. One nanosecond later it compares every output with that model, and it reads back the register named by the current offset. Directed sequences then confirm the ordering cases. These are capture while the status is set, a clear colliding with a refusal, and the unspecified attribute.

// File: rtl/sec_gate.sv
module sec_gate #(
  parameter int AW       = 16,
  parameter int BLK_LOG2 = 8,
  parameter int RAW      = 8,
  localparam int BW      = AW - BLK_LOG2,
  localparam int NBLK    = 1 << BW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tx_valid,
  input  logic [AW-1:0]   tx_addr,
  input  logic            tx_write,
  input  logic            tx_sec,
  input  logic            tx_attr_known,
  input  logic [15:0]     tx_master,
  input  logic [NBLK-1:0] table_bits,
  input  logic            err_resp_en,
  input  logic            reg_we,
  input  logic [RAW-1:0]  reg_addr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  output logic            fwd_valid,
  output logic [AW-1:0]   fwd_addr,
  output logic            fwd_write,
  output logic            deny_valid,
  output logic            deny_err,
  output logic [31:0]     deny_rdata,
  output logic            irq
);
  localparam logic [RAW-1:0] OFS_STAT  = RAW'(8'h20);
  localparam logic [RAW-1:0] OFS_CLR   = RAW'(8'h24);
  localparam logic [RAW-1:0] OFS_EN    = RAW'(8'h28);
  localparam logic [RAW-1:0] OFS_INFO1 = RAW'(8'h2c);
  localparam logic [RAW-1:0] OFS_INFO2 = RAW'(8'h30);
  localparam logic [RAW-1:0] OFS_SET   = RAW'(8'h34);

  logic          stat_q, en_q;
  logic [31:0]   info1_q, info2_q;

  wire [BW-1:0] blk_num  = tx_addr[AW-1:BLK_LOG2];
  wire          cfg_ns   = table_bits[blk_num];
  wire          non_sec  = tx_attr_known & ~tx_sec;
  wire          allow    = (cfg_ns == non_sec);
  wire          blocked  = tx_valid & ~allow;
  wire          clr_hit  = reg_we && reg_addr == OFS_CLR && reg_wdata[0];
  wire          set_hit  = reg_we && reg_addr == OFS_SET && reg_wdata[0];
  wire          en_hit   = reg_we && reg_addr == OFS_EN;
  wire          capture  = blocked & (~stat_q | clr_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fwd_valid  <= 1'b0;
      fwd_addr   <= '0;
      fwd_write  <= 1'b0;
      deny_valid <= 1'b0;
      deny_err   <= 1'b0;
    end else begin
      fwd_valid  <= tx_valid & allow;
      deny_valid <= blocked;
      if (tx_valid) begin
        fwd_addr  <= tx_addr;
        fwd_write <= tx_write;
      end
      if (blocked) deny_err <= err_resp_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q  <= 1'b0;
      en_q    <= 1'b1;
      info1_q <= '0;
      info2_q <= '0;
    end else begin
      if (capture) begin
        info1_q <= 32'(tx_addr);
        info2_q <= {14'd0, cfg_ns, non_sec, tx_master};
        stat_q  <= 1'b1;
      end else if (clr_hit) begin
        stat_q  <= 1'b0;
      end else if (set_hit) begin
        stat_q  <= 1'b1;
      end
      if (en_hit) en_q <= reg_wdata[0];
    end
  end

  always_comb begin
    case (reg_addr)
      OFS_STAT:  reg_rdata = {31'd0, stat_q};
      OFS_EN:    reg_rdata = {31'd0, en_q};
      OFS_INFO1: reg_rdata = info1_q;
      OFS_INFO2: reg_rdata = info2_q;
      default:   reg_rdata = 32'd0;
    endcase
  end

  assign deny_rdata = 32'd0;
  assign irq        = stat_q & en_q;
endmodule

// File: rtl/sec_gate_chk.sv
module sec_gate_chk #(
  parameter int AW       = 16,
  parameter int BLK_LOG2 = 8,
  parameter int RAW      = 8,
  localparam int NBLK    = 1 << (AW - BLK_LOG2)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            tx_valid,
  input logic [AW-1:0]   tx_addr,
  input logic            tx_sec,
  input logic            tx_attr_known,
  input logic [NBLK-1:0] table_bits,
  input logic            err_resp_en,
  input logic            reg_we,
  input logic [RAW-1:0]  reg_addr,
  input logic [31:0]     reg_wdata,
  input logic            fwd_valid,
  input logic [AW-1:0]   fwd_addr,
  input logic            deny_valid,
  input logic            deny_err,
  input logic            stat_q,
  input logic [31:0]     info1_q,
  input logic [31:0]     info2_q
);
  wire c_ns      = tx_attr_known && !tx_sec;
  wire c_refuse  = tx_valid && (table_bits[tx_addr[AW-1:BLK_LOG2]] != c_ns);
  wire c_admit   = tx_valid && !c_refuse;
  wire c_clr     = reg_we && reg_addr == RAW'(8'h24) && reg_wdata[0];
  wire c_set     = reg_we && reg_addr == RAW'(8'h34) && reg_wdata[0];

  a_r2_admit_forwards: assert property (@(posedge clk) disable iff (!rst_n)
    c_admit |=> fwd_valid && !deny_valid && fwd_addr == $past(tx_addr));

  a_r4_refuse_answers: assert property (@(posedge clk) disable iff (!rst_n)
    c_refuse |=> deny_valid && !fwd_valid && deny_err == $past(err_resp_en));

  a_r4_never_both: assert property (@(posedge clk) disable iff (!rst_n)
    !(fwd_valid && deny_valid));

  a_r6_record_held: assert property (@(posedge clk) disable iff (!rst_n)
    stat_q && !c_clr |=> $stable(info1_q) && $stable(info2_q) && stat_q);

  a_r9_capture_wins: assert property (@(posedge clk) disable iff (!rst_n)
    c_refuse && c_clr |=> stat_q && info1_q == 32'($past(tx_addr)));

  a_r8_set_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    c_set |=> stat_q);

  a_r8_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    c_clr && !c_refuse |=> !stat_q);
endmodule

bind sec_gate sec_gate_chk #(.AW(AW), .BLK_LOG2(BLK_LOG2), .RAW(RAW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_addr(tx_addr),
  .tx_sec(tx_sec), .tx_attr_known(tx_attr_known), .table_bits(table_bits),
  .err_resp_en(err_resp_en), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .fwd_valid(fwd_valid), .fwd_addr(fwd_addr),
  .deny_valid(deny_valid), .deny_err(deny_err), .stat_q(stat_q),
  .info1_q(info1_q), .info2_q(info2_q)
);

// File: tb/tb_sec_gate.sv
`timescale 1ns/1ps
module tb_sec_gate;
  localparam int AW = 12;
  localparam int BL = 5;
  localparam int NB = 1 << (AW - BL);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_valid = 0, tx_write = 0, tx_sec = 0, tx_known = 0;
  logic [AW-1:0] tx_addr = '0;
  logic [15:0] tx_master = '0;
  logic [NB-1:0] tbl = '0;
  logic err_en = 0, reg_we = 0;
  logic [7:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata, deny_rdata;
  logic fwd_valid, fwd_write, deny_valid, deny_err, irq;
  logic [AW-1:0] fwd_addr;

  sec_gate #(.AW(AW), .BLK_LOG2(BL), .RAW(8)) dut (
    .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_addr(tx_addr),
    .tx_write(tx_write), .tx_sec(tx_sec), .tx_attr_known(tx_known),
    .tx_master(tx_master), .table_bits(tbl), .err_resp_en(err_en),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .fwd_valid(fwd_valid), .fwd_addr(fwd_addr),
    .fwd_write(fwd_write), .deny_valid(deny_valid), .deny_err(deny_err),
    .deny_rdata(deny_rdata), .irq(irq)
  );

  always #2 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  logic m_stat, m_en, m_fv, m_fw, m_dv, m_de;
  logic [31:0] m_i1, m_i2;
  logic [AW-1:0] m_fa;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] m_read(input logic [7:0] a);
    case (a)
      8'h20: return {31'd0, m_stat};
      8'h28: return {31'd0, m_en};
      8'h2c: return m_i1;
      8'h30: return m_i2;
      default: return 32'd0;
    endcase
  endfunction

  function automatic string rd_tag(input logic [7:0] a);
    if (a == 8'h2c || a == 8'h30) return "R5";
    if (a == 8'h24 || a == 8'h34) return "R8";
    return "R7";
  endfunction

  task automatic compare_all();
    chk("R2 fwd_valid", 32'(fwd_valid), 32'(m_fv));
    if (m_fv) begin
      chk("R1 fwd_addr", 32'(fwd_addr), 32'(m_fa));
      chk("R2 fwd_write", 32'(fwd_write), 32'(m_fw));
    end
    chk("R4 deny_valid", 32'(deny_valid), 32'(m_dv));
    if (m_dv) begin
      chk("R4 deny_err", 32'(deny_err), 32'(m_de));
      chk("R4 deny_rdata", deny_rdata, 32'd0);
    end
    chk("R7 irq", 32'(irq), 32'(m_stat & m_en));
    chk(rd_tag(reg_addr), reg_rdata, m_read(reg_addr));
  endtask

  task automatic step();
    logic [AW-BL-1:0] blk;
    logic cfg, ns, refused, clr, setb, cap;
    logic n_stat, n_en, n_fv, n_fw, n_dv, n_de;
    logic [31:0] n_i1, n_i2;
    logic [AW-1:0] n_fa;
    blk = tx_addr >> BL;
    cfg = tbl[blk];
    ns = tx_known & ~tx_sec;
    refused = tx_valid && (cfg != ns);
    clr = reg_we && reg_addr == 8'h24 && reg_wdata[0];
    setb = reg_we && reg_addr == 8'h34 && reg_wdata[0];
    cap = refused && (!m_stat || clr);
    n_fv = tx_valid && !refused;
    n_fa = tx_valid ? tx_addr : m_fa;
    n_fw = tx_valid ? tx_write : m_fw;
    n_dv = refused;
    n_de = refused ? err_en : m_de;
    n_i1 = cap ? 32'(tx_addr) : m_i1;
    n_i2 = cap ? {14'd0, cfg, ns, tx_master} : m_i2;
    n_stat = cap ? 1'b1 : clr ? 1'b0 : setb ? 1'b1 : m_stat;
    n_en = (reg_we && reg_addr == 8'h28) ? reg_wdata[0] : m_en;
    @(posedge clk);
    #1;
    m_fv = n_fv; m_fa = n_fa; m_fw = n_fw; m_dv = n_dv; m_de = n_de;
    m_i1 = n_i1; m_i2 = n_i2; m_stat = n_stat; m_en = n_en;
    compare_all();
    @(negedge clk);
  endtask

  task automatic idle();
    tx_valid = 0; reg_we = 0;
  endtask

  task automatic do_tx(input logic [AW-1:0] a, input logic w, input logic s,
                       input logic k, input logic [15:0] m);
    tx_valid = 1; tx_addr = a; tx_write = w; tx_sec = s; tx_known = k; tx_master = m;
    step();
    idle();
  endtask

  task automatic do_reg(input logic [7:0] a, input logic [31:0] d);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    step();
    idle();
  endtask

  task automatic peek(input logic [7:0] a);
    reg_addr = a;
    step();
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_bad++;
      $display("FAIL R2 watchdog act=hung exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    m_stat = 0; m_en = 1; m_i1 = 0; m_i2 = 0;
    m_fv = 0; m_fa = '0; m_fw = 0; m_dv = 0; m_de = 0;
    reg_addr = 8'h28;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    // R10 reset state
    chk("R10 irq", 32'(irq), 0);
    chk("R10 fwd_valid", 32'(fwd_valid), 0);
    chk("R10 deny_valid", 32'(deny_valid), 0);
    chk("R10 enable", reg_rdata, 1);
    reg_addr = 8'h20; #0.1;
    chk("R10 status", reg_rdata, 0);
    reg_addr = 8'h2c; #0.1;
    chk("R10 info1", reg_rdata, 0);
    reg_addr = 8'h30; #0.1;
    chk("R10 info2", reg_rdata, 0);

    // R1/R2: bits at word edges, blocks 1, 31, 32, 127 non-secure
    tbl = '0;
    tbl[1] = 1; tbl[31] = 1; tbl[32] = 1; tbl[127] = 1;
    do_tx(12'h000, 0, 1, 1, 16'h0001);
    do_tx(12'h024, 1, 0, 1, 16'h0002);
    do_tx(12'h3e4, 0, 0, 1, 16'h0003);
    do_tx(12'h400, 1, 0, 1, 16'h0004);
    do_tx(12'h420, 1, 1, 1, 16'h0005);
    chk("R2 secure to secure block", 32'(fwd_valid), 1);
    do_tx(12'hfe0, 0, 0, 1, 16'h0006);

    // R3: unspecified attribute acts secure
    do_tx(12'h040, 0, 0, 0, 16'h0007);
    chk("R3 unspecified passes secure block", 32'(fwd_valid), 1);
    err_en = 0;
    do_tx(12'h028, 1, 0, 0, 16'h00a5);
    chk("R3 unspecified refused at non-secure block", 32'(deny_valid), 1);
    peek(8'h30);
    chk("R5 info2 fields", reg_rdata, {14'd0, 1'b1, 1'b0, 16'h00a5});
    peek(8'h2c);
    chk("R5 info1 addr", reg_rdata, 32'h028);

    // R6: second refusal with error response, record held
    err_en = 1;
    do_tx(12'h060, 0, 0, 1, 16'h0bad);
    chk("R4 error response", 32'(deny_err), 1);
    peek(8'h2c);
    chk("R6 info1 held", reg_rdata, 32'h028);

    // R9: clear and refusal in one cycle
    reg_we = 1; reg_addr = 8'h24; reg_wdata = 1;
    tx_valid = 1; tx_addr = 12'h3f0; tx_sec = 1; tx_known = 1; tx_master = 16'h0c0d;
    step(); idle();
    peek(8'h20);
    chk("R9 status kept", reg_rdata, 1);
    peek(8'h2c);
    chk("R9 new record", reg_rdata, 32'h3f0);

    // R8/R7: clear, enable off, set, read of write-only offsets
    do_reg(8'h24, 32'h1);
    chk("R8 cleared irq", 32'(irq), 0);
    do_reg(8'h28, 32'h0);
    do_reg(8'h34, 32'h1);
    chk("R7 masked irq", 32'(irq), 0);
    peek(8'h34);
    peek(8'h24);
    do_reg(8'h28, 32'h1);
    chk("R7 irq on enable", 32'(irq), 1);
    do_reg(8'h24, 32'h2);
    chk("R8 bit1 ignored", 32'(irq), 1);
    do_reg(8'h24, 32'h1);

    // mixed traffic
    for (int i = 0; i < 600; i++) begin
      if (i % 50 == 0) tbl = {$urandom, $urandom, $urandom, $urandom};
      tx_valid = ($urandom % 4) != 0;
      tx_addr = AW'($urandom);
      tx_write = 1'($urandom);
      tx_sec = 1'($urandom);
      tx_known = ($urandom % 5) != 0;
      tx_master = 16'($urandom);
      err_en = 1'($urandom);
      reg_we = ($urandom % 6) == 0;
      case ($urandom % 7)
        0: reg_addr = 8'h20;
        1: reg_addr = 8'h24;
        2: reg_addr = 8'h28;
        3: reg_addr = 8'h2c;
        4: reg_addr = 8'h30;
        5: reg_addr = 8'h34;
        default: reg_addr = 8'h3c;
      endcase
      reg_wdata = ($urandom % 3 == 0) ? 32'h0 : 32'($urandom) | 32'h1;
      step();
    end
    idle();
    step();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule